// File: doc/BRIEF.md
# JTAG-to-SPI Frame Sequencer

This block is the host-side JTAG master for a one-bit bridge data register that turns JTAG shifts into SPI clock cycles. A request names how many bypassed TAPs sit before and after the bridge in the chain, and gives the SPI cycle count minus one. The block generates TCK from the system clock and moves the TAP from Run-Test/Idle through Capture-DR into Shift-DR. It then shifts a framed sequence and returns to Run-Test/Idle.

The frame has four parts in order: zero padding for the upstream bypass bits, a single start marker, a 32-bit length word sent most significant bit first, and the payload. Zero bits follow the payload. Payload bits arrive on a valid/ready bit stream. TDO is sampled on every rising TCK edge, but only the bits that carry SPI read data are kept. The offset of those bits accounts for the downstream bypass latency and the bridge's one-cycle delay. The kept bits leave on a second valid/ready bit stream. If a stream stalls, TCK pauses, which JTAG tolerates. A one-cycle pulse marks the end of each transfer.

Top module: `jsb_host`

## Requirements
- R1: After reset, tck, tms, tdi, tx_ready, rx_valid and done are 0 and req_ready is 1.
- R2: Each TCK period is DIV_HALF system cycles low followed by DIV_HALF cycles high, unless a stream stalls it. tms and tdi change only where TCK falls or while TCK is idle, and never at a rising edge.
- R3: The TMS values seen at successive rising TCK edges are 1,0,0 to reach Shift-DR. They are 0 during the shift bits except the final one, which is 1. Then come 1,0 back to Run-Test/Idle.
- R4: Shift bits 0..pre-1 are 0, bit pre is 1, and bits pre+1..pre+32 carry req_len most significant bit first. req_len is the SPI cycle count minus one.
- R5: Bits pre+33..pre+33+req_len carry req_len+1 payload bits in stream order. tx_ready is high only while tx_valid is high, for exactly one cycle per bit. A req_len of 0 still sends one payload bit.
- R6: After the payload, post+1 zero bits follow. The shift is therefore pre+req_len+post+35 bits long, and a transfer has pre+req_len+post+40 rising TCK edges.
- R7: Read bit i is the TDO value sampled at the rising edge of shift bit pre+34+post+i. Exactly req_len+1 read bits are delivered, and all other TDO bits are discarded.
- R8: While rx_valid is high and rx_ready is low, no further TCK edge is produced. A payload bit that is due while tx_valid is low also holds TCK until the bit is offered.
- R9: done pulses for one cycle after the last TCK edge, with TCK low. req_ready is low from acceptance until that pulse, so requests made while busy are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Sequencer idle; request accepted when both high |
| req_pre | input | PRE_W | Number of bypassed TAPs between TDI and the bridge |
| req_post | input | POST_W | Number of bypassed TAPs between the bridge and TDO |
| req_len | input | 32 | SPI cycle count minus one |
| tx_valid | input | 1 | Payload bit offered |
| tx_ready | output | 1 | Payload bit taken this cycle |
| tx_bit | input | 1 | Payload bit |
| rx_valid | output | 1 | Read bit held for the consumer |
| rx_ready | input | 1 | Consumer takes the read bit |
| rx_bit | output | 1 | Read bit |
| tck | output | 1 | Generated JTAG clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data toward the chain |
| tdo | input | 1 | JTAG data from the chain |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench indexes every result by rising TCK edges counted from the request, not by system cycles. TMS and TDI are logged at each rising edge. TDO is driven at each falling edge from a pattern keyed to the shift index, so the bit the sequencer samples at the next rise is known exactly. The bench waits for done, which comes one system cycle after the final high phase. Only then does it compare edge counts, logs, consumed payload bits and delivered read bits against values it computes from the frame layout. Stall checks sample the edge count 40 cycles after the stall starts, which is many TCK periods later.

// File: rtl/jsb_pkg.sv
package jsb_pkg;
   localparam int LEN_FIELD_W = 32;

   typedef enum logic [3:0] {
      ST_IDLE, ST_NAV_IN, ST_PRE, ST_MARK, ST_LEN,
      ST_DATA, ST_TAIL, ST_NAV_OUT, ST_END
   } seq_st_e;

   typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} tck_ph_e;
endpackage

// File: rtl/jsb_tck_gen.sv
module jsb_tck_gen import jsb_pkg::*; #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic busy,
   output logic tck,
   output logic slot,
   output logic rise
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   tck_ph_e ph, ph_nxt;
   logic    cnt_zero;

   generate
      if (DIV_HALF < 1) begin : g_bad
         $error("DIV_HALF must be at least 1");
      end
      if (DIV_HALF == 1) begin : g_nodiv
         assign cnt_zero = 1'b1;
      end else begin : g_div
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            cnt <= '0;
            else if (go || (ph == PH_LO && cnt_zero)) cnt <= CW'(DIV_HALF - 1);
            else if (cnt != '0)                    cnt <= cnt - 1'b1;
         end
         assign cnt_zero = (cnt == '0);
      end
   endgenerate

   assign slot = (ph == PH_IDLE) || (ph == PH_HI && cnt_zero);
   assign rise = (ph == PH_LO) && cnt_zero;

   always_comb begin
      ph_nxt = ph;
      if (go)                                   ph_nxt = PH_LO;
      else if (rise)                            ph_nxt = PH_HI;
      else if (ph == PH_HI && cnt_zero && !busy) ph_nxt = PH_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         tck <= 1'b0;
      end else begin
         ph  <= ph_nxt;
         tck <= (ph_nxt == PH_HI);
      end
   end
endmodule

// File: rtl/jsb_step_seq.sv
module jsb_step_seq import jsb_pkg::*; #(
   parameter int PRE_W  = 4,
   parameter int POST_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [PRE_W-1:0]       req_pre,
   input  logic [POST_W-1:0]      req_post,
   input  logic [LEN_FIELD_W-1:0] req_len,
   input  logic                   slot,
   input  logic                   rx_stall,
   output logic                   go,
   output logic                   busy,
   input  logic                   tx_valid,
   output logic                   tx_ready,
   input  logic                   tx_bit,
   output logic                   tms,
   output logic                   tdi,
   output logic                   cap,
   output logic                   done
);
   localparam int SKIP_W = POST_W + 1;
   localparam int LB_W   = $clog2(LEN_FIELD_W);

   seq_st_e                st;
   logic [1:0]             nav;
   logic [PRE_W-1:0]       pcnt;
   logic [SKIP_W-1:0]      skip;
   logic [LB_W-1:0]        lbit;
   logic [LEN_FIELD_W-1:0] len_q, dleft, rrem;

   assign req_ready = (st == ST_IDLE);
   assign busy      = (st != ST_IDLE) && (st != ST_END);
   assign go        = slot && busy && !rx_stall && !(st == ST_DATA && !tx_valid);
   assign tx_ready  = go && (st == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; nav <= '0; pcnt <= '0; skip <= '0; lbit <= '0;
         len_q <= '0; dleft <= '0; rrem <= '0;
         tms <= 1'b0; tdi <= 1'b0; cap <= 1'b0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st == ST_IDLE && req_valid) begin
            st    <= ST_NAV_IN;
            nav   <= '0;
            pcnt  <= req_pre;
            skip  <= SKIP_W'(req_post) + 1'b1;
            len_q <= req_len;
            dleft <= req_len;
            rrem  <= req_len;
         end else if (st == ST_END && slot) begin
            done <= 1'b1;
            st   <= ST_IDLE;
         end
         if (go) begin
            tms <= 1'b0;
            tdi <= 1'b0;
            cap <= 1'b0;
            unique case (st)
               ST_NAV_IN: begin
                  tms <= (nav == 2'd0);
                  nav <= nav + 1'b1;
                  if (nav == 2'd2) st <= (pcnt == '0) ? ST_MARK : ST_PRE;
               end
               ST_PRE: begin
                  pcnt <= pcnt - 1'b1;
                  if (pcnt == PRE_W'(1)) st <= ST_MARK;
               end
               ST_MARK: begin
                  tdi  <= 1'b1;
                  lbit <= LB_W'(LEN_FIELD_W - 1);
                  st   <= ST_LEN;
               end
               ST_LEN: begin
                  tdi  <= len_q[lbit];
                  lbit <= lbit - 1'b1;
                  if (lbit == '0) st <= ST_DATA;
               end
               ST_DATA: begin
                  tdi <= tx_bit;
                  if (dleft == '0) st <= ST_TAIL;
                  else             dleft <= dleft - 1'b1;
               end
               ST_NAV_OUT: begin
                  tms <= (nav == 2'd0);
                  nav <= nav + 1'b1;
                  if (nav == 2'd1) st <= ST_END;
               end
               default: ;
            endcase
            // read-bit alignment runs across payload and tail bits
            if (st == ST_DATA || st == ST_TAIL) begin
               if (skip != '0) skip <= skip - 1'b1;
               else begin
                  cap  <= 1'b1;
                  rrem <= rrem - 1'b1;
                  if (rrem == '0) begin
                     tms <= 1'b1;
                     st  <= ST_NAV_OUT;
                     nav <= '0;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/jsb_host.sv
module jsb_host import jsb_pkg::*; #(
   parameter int DIV_HALF = 2,
   parameter int PRE_W    = 4,
   parameter int POST_W   = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [PRE_W-1:0]       req_pre,
   input  logic [POST_W-1:0]      req_post,
   input  logic [LEN_FIELD_W-1:0] req_len,
   input  logic                   tx_valid,
   output logic                   tx_ready,
   input  logic                   tx_bit,
   output logic                   rx_valid,
   input  logic                   rx_ready,
   output logic                   rx_bit,
   output logic                   tck,
   output logic                   tms,
   output logic                   tdi,
   input  logic                   tdo,
   output logic                   done
);
   logic go, busy, slot, rise, cap, rx_stall;

   assign rx_stall = rx_valid && !rx_ready;

   jsb_tck_gen #(.DIV_HALF(DIV_HALF)) u_tck (
      .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
      .tck(tck), .slot(slot), .rise(rise)
   );

   jsb_step_seq #(.PRE_W(PRE_W), .POST_W(POST_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_pre(req_pre), .req_post(req_post), .req_len(req_len),
      .slot(slot), .rx_stall(rx_stall), .go(go), .busy(busy),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
      .tms(tms), .tdi(tdi), .cap(cap), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid <= 1'b0;
         rx_bit   <= 1'b0;
      end else if (rise && cap) begin
         rx_valid <= 1'b1;
         rx_bit   <= tdo;
      end else if (rx_ready) begin
         rx_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/jsb_host_chk.sv
module jsb_host_chk (
   input logic clk,
   input logic rst_n,
   input logic tck,
   input logic tms,
   input logic tdi,
   input logic tx_valid,
   input logic tx_ready,
   input logic rx_valid,
   input logic rx_ready,
   input logic rx_bit,
   input logic req_ready,
   input logic done
);
   a_r2_pins_still_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tck) |-> ($stable(tms) && $stable(tdi)));

   a_r5_take_only_offered: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> tx_valid);

   a_r8_read_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_bit)));

   a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!tck && req_ready));
endmodule

bind jsb_host jsb_host_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
   .rx_ready(rx_ready), .rx_bit(rx_bit), .req_ready(req_ready), .done(done)
);

// File: tb/tb_jsb_host.sv
module tb_jsb_host;
   localparam int DIV_HALF = 2;
   localparam int PRE_W = 4, POST_W = 4;
   localparam int NV = 6;
   // pre, post, len, seed, mode (0 plain, 1 read stall, 2 payload starve)
   localparam int VEC [0:NV-1][0:4] = '{
      '{0, 0, 0, 1, 0}, '{1, 0, 7, 2, 0}, '{2, 3, 7, 3, 1},
      '{15, 15, 12, 4, 0}, '{3, 1, 0, 5, 2}, '{0, 5, 20, 6, 0}};

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_ready;
   logic [PRE_W-1:0] req_pre = '0;
   logic [POST_W-1:0] req_post = '0;
   logic [31:0] req_len = '0;
   logic tx_valid = 1, tx_ready, tx_bit;
   logic rx_valid, rx_ready = 1, rx_bit;
   logic tck, tms, tdi, tdo = 0, done;

   int nchk = 0, nfail = 0;
   int cur_seed = 0, n0 = 0, tx0 = 0, rx0 = 0, d0 = 0;
   int n_rise = 0, tx_idx = 0, rx_idx = 0, n_done = 0;
   bit tms_log [0:511];
   bit tdi_log [0:511];
   bit rx_log  [0:511];
   realtime t_rise [0:1];

   always #4 clk = ~clk;

   jsb_host #(.DIV_HALF(DIV_HALF), .PRE_W(PRE_W), .POST_W(POST_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_pre(req_pre), .req_post(req_post), .req_len(req_len),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bit(rx_bit),
      .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .done(done));

   function automatic bit pay_pat(int i, int seed);
      return ((i * 5 + seed * 7) % 3) == 1;
   endfunction

   function automatic bit tdo_pat(int k, int seed);
      int r;
      if (k < 0) return 1'b0;
      r = (k * 3 + seed) % 7;
      return (r == 1) || (r == 2) || (r == 4);
   endfunction

   assign tx_bit = pay_pat(tx_idx - tx0, cur_seed);

   always @(posedge tck) begin
      int j;
      j = n_rise - n0;
      if (j >= 0 && j < 512) begin tms_log[j] = tms; tdi_log[j] = tdi; end
      if (j >= 0 && j < 2) t_rise[j] = $realtime;
      n_rise = n_rise + 1;
   end

   always @(negedge tck) tdo = tdo_pat(n_rise - n0 - 3, cur_seed);

   always @(posedge clk) begin
      if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
      if (rx_valid && rx_ready) begin
         if (rx_idx - rx0 < 512) rx_log[rx_idx - rx0] <= rx_bit;
         rx_idx <= rx_idx + 1;
      end
      if (done) n_done <= n_done + 1;
   end

   task automatic chk(string req, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_xfer(int pre, int post, int len, int seed, int mode);
      int S, steps, bad_tms, bad_tdi, bad_rx, snap;
      bit et, ed;
      cur_seed = seed; n0 = n_rise; tx0 = tx_idx; rx0 = rx_idx; d0 = n_done;
      if (mode == 1) rx_ready = 0;
      if (mode == 2) tx_valid = 0;
      @(negedge clk);
      req_valid = 1; req_pre = PRE_W'(pre); req_post = POST_W'(post); req_len = len;
      @(negedge clk);
      req_valid = 0;
      chk("R9", "req_ready while busy", int'(req_ready), 0);
      if (mode == 1) begin
         while (!rx_valid) @(negedge clk);
         snap = n_rise;
         repeat (40) @(negedge clk);
         chk("R8", "tck edges during read stall", n_rise - snap, 0);
         chk("R8", "rx_valid held", int'(rx_valid), 1);
         rx_ready = 1;
      end
      if (mode == 2) begin
         while (n_rise - n0 < pre + 36) @(negedge clk);
         repeat (40) @(negedge clk);
         chk("R8", "edges while payload missing", n_rise - n0, pre + 36);
         chk("R5", "tx_ready without valid", int'(tx_ready), 0);
         tx_valid = 1;
      end
      while (n_done == d0) @(negedge clk);
      @(negedge clk);
      S = pre + len + post + 35;
      steps = S + 5;
      chk("R6", "rising TCK edges", n_rise - n0, pre + len + post + 40);
      bad_tms = 0; bad_tdi = 0; bad_rx = 0;
      for (int n = 0; n < steps && n < 512; n++) begin
         int k;
         k = n - 3;
         et = (n == 0) || (n == 3 + S - 1) || (n == 3 + S);
         if (k < 0 || k >= S)          ed = 1'b0;
         else if (k < pre)             ed = 1'b0;
         else if (k == pre)            ed = 1'b1;
         else if (k < pre + 33)        ed = (len >> (31 - (k - pre - 1))) & 1;
         else if (k < pre + 34 + len)  ed = pay_pat(k - pre - 33, seed);
         else                          ed = 1'b0;
         if (tms_log[n] != et) bad_tms++;
         if (tdi_log[n] != ed) bad_tdi++;
      end
      chk("R3", "TMS mismatches", bad_tms, 0);
      chk("R4", "TDI frame mismatches", bad_tdi, 0);
      chk("R5", "payload bits taken", tx_idx - tx0, len + 1);
      chk("R7", "read bits delivered", rx_idx - rx0, len + 1);
      for (int i = 0; i <= len; i++)
         if (rx_log[i] != tdo_pat(pre + 34 + post + i, seed)) bad_rx++;
      chk("R7", "read bit mismatches", bad_rx, 0);
      chk("R9", "done pulses", n_done - d0, 1);
      chk("R9", "req_ready after done", int'(req_ready), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle values after reset
      chk("R1", "tck", int'(tck), 0);
      chk("R1", "tms", int'(tms), 0);
      chk("R1", "tdi", int'(tdi), 0);
      chk("R1", "req_ready", int'(req_ready), 1);
      chk("R1", "rx_valid", int'(rx_valid), 0);
      chk("R1", "tx_ready", int'(tx_ready), 0);
      chk("R1", "done", int'(done), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      for (int v = 0; v < NV; v++) begin
         run_xfer(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
         if (v == 0)  // R2: unstalled TCK period is two half periods
            chk("R2", "TCK period ns", int'(t_rise[1] - t_rise[0]), 2 * DIV_HALF * 8);
         repeat (3) @(negedge clk);
      end
      chk("R1", "tck idle after transfers", int'(tck), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule